// File: doc/BRIEF.md
# Scanned Display Digit Latch

This block holds one digit's share of a finished count so that a multiplexed display can keep showing it while the next measurement runs. New data is taken only when the measurement is over and a transfer strobe is present. The capture happens on the following clock edge. While a measurement is active the stored value stays frozen, whatever the transfer input does.

The block keeps its own 3-bit display scan position, which advances on a step input. The position is shifted by a fixed offset, modulo 8, before it is compared with the slot given to this latch. The held value is driven out only in the one scan position out of eight whose shifted value matches the slot. In every other position the enable flag is low and the data output reads zero, which stands in for a released, high-impedance bus.

Top module: `scan_digit_latch`

## Requirements
- R1: After reset, the held value is zero and the scan position is zero.
- R2: On a rising clock edge where `xfer` is 1 and `meas_active` is 0, `din` is stored. From the next cycle the stored value is what `dout` shows whenever it is enabled.
- R3: On an edge where `meas_active` is 1, the held value does not change, even if `xfer` is 1.
- R4: On an edge where `xfer` is 0, the held value does not change.
- R5: `scan_addr` rises by one on each edge where `scan_step` is 1 and wraps from 7 to 0. It holds its value on edges where `scan_step` is 0.
- R6: `dout_en` is 1 exactly when `(scan_addr + OFFSET) mod 8` equals `SLOT`. This makes it high for one scan position in eight. With the defaults OFFSET=5 and SLOT=2, that position is `scan_addr` = 5.
- R7: While `dout_en` is 1, `dout` equals the held value. While `dout_en` is 0, `dout` is all zeros.
- R8: Suppose a load and the selected scan position fall in the same cycle. Then `dout` shows the previous held value until the edge and the new value after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| meas_active | input | 1 | High while a measurement is running; blocks loading |
| xfer | input | 1 | Transfer strobe; requests a load at the next edge |
| din | input | DW | Count data to be held |
| scan_step | input | 1 | Advances the display scan position |
| scan_addr | output | 3 | Current display scan position |
| dout | output | DW | Held data while selected, zero otherwise |
| dout_en | output | 1 | High in the one selected scan position |

## Verification
A load and the digit's output window can land in the same cycle. To provoke this, the bench parks the scan position on the selected slot and raises `xfer` with fresh data. It then reads `dout` before the edge, expecting the old value, and again after the edge, expecting the new value. The bench also raises `xfer` inside the selected slot while a measurement is active. In that case `dout` must keep the old value across the edge.

// File: rtl/scan_digit_latch.sv
module scan_digit_latch #(
  parameter int DW     = 16,
  parameter int OFFSET = 5,
  parameter int SLOT   = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          meas_active,
  input  logic          xfer,
  input  logic [DW-1:0] din,
  input  logic          scan_step,
  output logic [2:0]    scan_addr,
  output logic [DW-1:0] dout,
  output logic          dout_en
);
  localparam logic [2:0] OFS = 3'(OFFSET);
  localparam logic [2:0] SEL = 3'(SLOT);

  logic [DW-1:0] held_q;
  logic [2:0]    scan_q;
  logic [2:0]    mapped;
  logic          load;

  assign load   = xfer & ~meas_active;
  assign mapped = scan_q + OFS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= '0;
      scan_q <= '0;
    end else begin
      if (load) held_q <= din;
      if (scan_step) scan_q <= scan_q + 3'd1;
    end
  end

  assign scan_addr = scan_q;
  assign dout_en   = (mapped == SEL);
  assign dout      = dout_en ? held_q : '0;
endmodule

// File: rtl/scan_digit_latch_chk.sv
module scan_digit_latch_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          meas_active,
  input logic          xfer,
  input logic [DW-1:0] din,
  input logic          scan_step,
  input logic [2:0]    scan_addr,
  input logic [DW-1:0] dout,
  input logic          dout_en,
  input logic [DW-1:0] held_q
);
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !meas_active) |=> held_q == $past(din)); // R2
  AST_MEAS_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    meas_active |=> $stable(held_q)); // R3
  AST_NO_XFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(held_q)); // R4
  AST_SCAN_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    scan_step |=> scan_addr == 3'($past(scan_addr) + 3'd1)); // R5
  AST_SCAN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_step |=> $stable(scan_addr)); // R5
  AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> dout == '0); // R7
  AST_ON_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> dout == held_q); // R7
  AST_STEADY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_step |=> dout_en == $past(dout_en)); // R6
endmodule

bind scan_digit_latch scan_digit_latch_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .meas_active(meas_active), .xfer(xfer),
  .din(din), .scan_step(scan_step), .scan_addr(scan_addr), .dout(dout),
  .dout_en(dout_en), .held_q(held_q)
);

// File: tb/tb_scan_digit_latch.sv
module tb_scan_digit_latch;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int OFFSET = 5;
  localparam int SLOT = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          meas_active = 1'b0;
  logic          xfer = 1'b0;
  logic [DW-1:0] din = '0;
  logic          scan_step = 1'b0;
  logic [2:0]    scan_addr;
  logic [DW-1:0] dout;
  logic          dout_en;

  int n_cmp = 0;
  int n_bad = 0;
  logic [DW-1:0] m_held;
  logic [2:0]    m_scan;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_digit_latch #(.DW(DW), .OFFSET(OFFSET), .SLOT(SLOT)) dut (
    .clk(clk), .rst_n(rst_n), .meas_active(meas_active), .xfer(xfer),
    .din(din), .scan_step(scan_step), .scan_addr(scan_addr),
    .dout(dout), .dout_en(dout_en)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic exp_en(logic [2:0] s);
    return ((int'(s) + OFFSET) % 8) == SLOT;
  endfunction

  task automatic check_outs(string req);
    logic e;
    e = exp_en(m_scan);
    chk({req, " scan"}, 32'(scan_addr), 32'(m_scan));
    chk({req, " en"}, 32'(dout_en), 32'(e));
    chk({req, " dout"}, 32'(dout), e ? 32'(m_held) : 32'd0);
  endtask

  task automatic cyc(string req, logic ma, logic x, logic [DW-1:0] d, logic st);
    @(negedge clk);
    meas_active = ma; xfer = x; din = d; scan_step = st;
    @(posedge clk);
    if (x && !ma) m_held = d;
    if (st) m_scan = m_scan + 3'd1;
    #1;
    check_outs(req);
  endtask

  task automatic goto_slot();
    while (!exp_en(m_scan)) cyc("R5 seek", 1'b0, 1'b0, '0, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    m_held = '0; m_scan = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check_outs("R1 reset");

    // R5/R6/R7: full wrap with zero held
    for (int i = 0; i < 10; i++) cyc("R5 R6 sweep", 1'b0, 1'b0, '0, 1'b1);

    // R2: loads of several patterns, each swept through all 8 positions
    for (int p = 0; p < 6; p++) begin
      logic [DW-1:0] v;
      v = DW'(16'h1234 * (p + 1) ^ (16'hA5A5 >> p));
      cyc("R2 load", 1'b0, 1'b1, v, 1'b0);
      for (int s = 0; s < 8; s++) cyc("R2 R7 show", 1'b0, 1'b0, '0, 1'b1);
    end

    // R3: transfer during measurement ignored, checked in the slot
    goto_slot();
    for (int k = 0; k < 4; k++)
      cyc("R3 lockout", 1'b1, 1'b1, DW'(16'hBEEF + k), 1'b0);
    cyc("R3 data only", 1'b1, 1'b0, 16'h0F0F, 1'b0);

    // R4: no xfer, data changing, value held
    for (int k = 0; k < 4; k++) cyc("R4 hold", 1'b0, 1'b0, DW'(16'h7777 + k), 1'b0);

    // R8: load and selected slot in the same cycle
    goto_slot();
    @(negedge clk);
    meas_active = 1'b0; xfer = 1'b1; din = 16'hC3C3; scan_step = 1'b0;
    #1;
    chk("R8 before edge", 32'(dout), 32'(m_held));
    @(posedge clk);
    m_held = 16'hC3C3;
    #1;
    check_outs("R8 after edge");

    // R5: scan holds when not stepped
    for (int k = 0; k < 3; k++) cyc("R5 hold", 1'b0, 1'b0, '0, 1'b0);

    // R1: reset again
    @(negedge clk); rst_n = 1'b0; xfer = 1'b0;
    @(posedge clk); m_held = '0; m_scan = '0;
    #1;
    check_outs("R1 re-reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule